// File: doc/BRIEF.md
# Multiplexed Seven-Pin I/O Port

This block is a seven-pin general-purpose I/O port whose pins can be taken over by external-bus functions. It holds a write-only direction register and an output data register, both reached through a small register write/read path. Each pin goes to one of three pin functions, and the choice depends on the operating mode, an expansion enable and the enable bits that an external bus controller supplies. The three pin functions are plain I/O, alternate output and alternate input.

Pins 6 and 5 can serve bus-request arbitration: pin 6 takes an incoming request and pin 5 drives the acknowledge. Pin 4 can drive a bus-request-out signal or chip select 7. Pins 3 to 0 can drive chip selects 3 to 0. On a chip-select pin whose enable is set, the direction bit selects between driving the chip select and acting as an input. The bus arbiter and the address decoder that produce these signals sit outside the block.

The per-pin selection is a function code, not a sequential machine. It is an enumerated type with three members: `FN_IO`, `FN_ALT_OUT` and `FN_ALT_IN`. A `unique case` on this code picks each pin's driver. The code has no transitions in time, because it is recomputed combinationally on every cycle.

Top module: `gpio_altfn_port`

## Requirements
- R1: Reset is synchronous, with `rst_n` low at a clock edge. It clears the data register and direction bits 6 to 1. Direction bit 0 resets to 1 when `mode_i` is 1 or 2, and to 0 for every other mode code.
- R2: The direction register is write-only. A read with `rd_sel_i`=1 returns 8'hFF. On a direction write (`wr_sel_i`=1), data bit 7 is discarded and bits 6..0 load direction bits 6..0.
- R3: A port read (`rd_sel_i`=0) returns the following. Bit 7 reads 1. For a pin in `FN_IO` with direction bit 1, the bit is the data-register value. For every other pin, the bit is the live `pin_i` level.
- R4: A data write (`wr_en_i`=1, `wr_sel_i`=0) changes `pin_o` on output pins at the first rising edge after the write is presented, and not before.
- R5: A pin in `FN_IO` has `pin_oe_o` equal to its direction bit. When that bit is 1, `pin_o` equals its data-register bit.
- R6: Arbitration applies when the port is expanded and `busarb_en_i`=1. Pin 6 is then an input (oe 0) and `breq_n_o` follows `pin_i[6]`. Pin 5 drives `back_n_i` with oe 1. In every other case, `breq_n_o` is 1.
- R7: When the port is expanded and `reqo_en_i`=1, pin 4 drives `breqo_n_i` with oe 1. This holds whatever `cs_en_i[4]` and direction bit 4 are set to.
- R8: On an expanded port, take a chip-select pin k with `cs_en_i[k]`=1 (k=4 only when `reqo_en_i`=0). With direction bit 1, the pin drives `cs_n_i[k]` with oe 1. With direction bit 0, the pin is an input with oe 0.
- R9: When the port is not expanded, every pin is in `FN_IO` and all alternate enables are ignored.
- R10: The port is expanded for mode codes 1, 2 and 4 whatever `expe_i` is set to. For code 7 it is expanded only when `expe_i`=1. Every other code is treated like code 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 3 | Operating mode code |
| expe_i | input | 1 | External expansion enable |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 data, 1 direction |
| wr_data_i | input | 8 | Write data |
| rd_sel_i | input | 1 | Read target: 0 port, 1 direction |
| rd_data_o | output | 8 | Read data |
| busarb_en_i | input | 1 | Bus-request arbitration enable (pins 6/5) |
| reqo_en_i | input | 1 | Bus-request-out enable (pin 4) |
| cs_en_i | input | 5 | Chip-select enables; bit 4 is CS7, bits 3..0 CS3..CS0 |
| cs_n_i | input | 5 | Chip-select levels, same bit order |
| back_n_i | input | 1 | Bus acknowledge level for pin 5 |
| breqo_n_i | input | 1 | Bus-request-out level for pin 4 |
| breq_n_o | output | 1 | Bus request sampled from pin 6 |
| pin_i | input | 7 | Pin input levels |
| pin_o | output | 7 | Pin output values |
| pin_oe_o | output | 7 | Pin output enables |

## Verification
Some properties are checked by assertions on every cycle:
- Without expansion, every pin follows the two registers.
- The acknowledge pin is driven whenever arbitration is active.
- A chip-select pin whose direction bit is clear is released.
- Bus-request-out overrides chip select 7 on pin 4.
- Direction and data bits clear after reset.
- A data write lands one edge later.

Only the bench's scenarios can show certain results:
- The mode-dependent reset of direction bit 0 in each mode.
- The all-ones direction read.
- The mixed port-read value.
- The exact output word for each combination of enables.

// File: rtl/gpiop_pkg.sv
package gpiop_pkg;

    localparam int NPINS   = 7;
    localparam int NCS     = 5;
    localparam int PIN_REQ = 6;
    localparam int PIN_ACK = 5;
    localparam int PIN_RQO = 4;

    localparam logic [2:0] MODE_EXP1 = 3'd1;
    localparam logic [2:0] MODE_EXP2 = 3'd2;
    localparam logic [2:0] MODE_EXP4 = 3'd4;

    typedef enum logic [1:0] {
        FN_IO      = 2'd0,
        FN_ALT_OUT = 2'd1,
        FN_ALT_IN  = 2'd2
    } pin_fn_e;

    function automatic logic is_expanded(input logic [2:0] mode, input logic expe);
        return (mode == MODE_EXP1) || (mode == MODE_EXP2) ||
               (mode == MODE_EXP4) || expe;
    endfunction

    function automatic logic dir0_boot(input logic [2:0] mode);
        return (mode == MODE_EXP1) || (mode == MODE_EXP2);
    endfunction

endpackage

// File: rtl/gpiop_regs.sv
module gpiop_regs #(
    parameter int NPINS = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             boot_dir0,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [7:0]       wr_data,
    output logic [NPINS-1:0] ddr_q,
    output logic [NPINS-1:0] dr_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ddr_q <= {{(NPINS-1){1'b0}}, boot_dir0};
            dr_q  <= '0;
        end else if (wr_en) begin
            if (wr_sel) ddr_q <= wr_data[NPINS-1:0];
            else        dr_q  <= wr_data[NPINS-1:0];
        end
    end

    logic seen_reset;
    always_ff @(posedge clk) begin
        if (!rst_n) seen_reset <= 1'b1;
        else if (seen_reset === 1'bx) seen_reset <= 1'b0;
    end

    // R1: right after reset, upper direction bits and data are clear
    a_r1_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_reset === 1'b1 && $past(!rst_n)) |->
            (ddr_q[NPINS-1:1] == '0 && dr_q == '0));

    // R4: a data write lands at the next edge
    a_r4_data_next_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_reset === 1'b1 && $past(rst_n) && $past(wr_en) && !$past(wr_sel)) |->
            (dr_q == $past(wr_data[NPINS-1:0])));

endmodule

// File: rtl/gpiop_fn_sel.sv
module gpiop_fn_sel
    import gpiop_pkg::*;
#(
    parameter int NP  = 7,
    parameter int NCSP = 4
) (
    input  logic                 ext,
    input  logic                 busarb_en,
    input  logic                 reqo_en,
    input  logic [NCSP:0]        cs_en,
    input  logic [NP-1:0]        ddr,
    output pin_fn_e [NP-1:0]     fn_o
);

    // pins 6/5: arbitration request input and acknowledge output
    always_comb begin
        fn_o[PIN_REQ] = (ext && busarb_en) ? FN_ALT_IN  : FN_IO;
        fn_o[PIN_ACK] = (ext && busarb_en) ? FN_ALT_OUT : FN_IO;
    end

    // pin 4: request-out wins over chip select 7
    always_comb begin
        if (ext && reqo_en)
            fn_o[PIN_RQO] = FN_ALT_OUT;
        else if (ext && cs_en[NCSP])
            fn_o[PIN_RQO] = ddr[PIN_RQO] ? FN_ALT_OUT : FN_ALT_IN;
        else
            fn_o[PIN_RQO] = FN_IO;
    end

    // pins 3..0: chip selects, direction bit chooses drive vs input
    for (genvar k = 0; k < NCSP; k++) begin : g_cs
        always_comb begin
            if (ext && cs_en[k])
                fn_o[k] = ddr[k] ? FN_ALT_OUT : FN_ALT_IN;
            else
                fn_o[k] = FN_IO;
        end
    end

endmodule

// File: rtl/gpiop_pin_drv.sv
module gpiop_pin_drv
    import gpiop_pkg::*;
#(
    parameter int NP = 7
) (
    input  pin_fn_e [NP-1:0] fn,
    input  logic [NP-1:0]    ddr,
    input  logic [NP-1:0]    dr,
    input  logic [NP-1:0]    alt_val,
    input  logic [NP-1:0]    pin_i,
    output logic [NP-1:0]    pin_o,
    output logic [NP-1:0]    pin_oe_o,
    output logic [NP-1:0]    rd_bits
);

    for (genvar i = 0; i < NP; i++) begin : g_pin
        always_comb begin
            unique case (fn[i])
                FN_IO: begin
                    pin_oe_o[i] = ddr[i];
                    pin_o[i]    = dr[i];
                    rd_bits[i]  = ddr[i] ? dr[i] : pin_i[i];
                end
                FN_ALT_OUT: begin
                    pin_oe_o[i] = 1'b1;
                    pin_o[i]    = alt_val[i];
                    rd_bits[i]  = pin_i[i];
                end
                FN_ALT_IN: begin
                    pin_oe_o[i] = 1'b0;
                    pin_o[i]    = 1'b0;
                    rd_bits[i]  = pin_i[i];
                end
                default: begin
                    pin_oe_o[i] = 1'b0;
                    pin_o[i]    = 1'b0;
                    rd_bits[i]  = pin_i[i];
                end
            endcase
        end
    end

endmodule

// File: rtl/gpio_altfn_port.sv
module gpio_altfn_port
    import gpiop_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       mode_i,
    input  logic             expe_i,
    input  logic             wr_en_i,
    input  logic             wr_sel_i,
    input  logic [7:0]       wr_data_i,
    input  logic             rd_sel_i,
    output logic [7:0]       rd_data_o,
    input  logic             busarb_en_i,
    input  logic             reqo_en_i,
    input  logic [NCS-1:0]   cs_en_i,
    input  logic [NCS-1:0]   cs_n_i,
    input  logic             back_n_i,
    input  logic             breqo_n_i,
    output logic             breq_n_o,
    input  logic [NPINS-1:0] pin_i,
    output logic [NPINS-1:0] pin_o,
    output logic [NPINS-1:0] pin_oe_o
);

    localparam int NCSP = NCS - 1;

    logic             ext;
    logic [NPINS-1:0] ddr_q, dr_q, alt_val, rd_bits;
    pin_fn_e [NPINS-1:0] fn;

    assign ext = is_expanded(mode_i, expe_i);

    gpiop_regs #(.NPINS(NPINS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .boot_dir0 (dir0_boot(mode_i)),
        .wr_en     (wr_en_i),
        .wr_sel    (wr_sel_i),
        .wr_data   (wr_data_i),
        .ddr_q     (ddr_q),
        .dr_q      (dr_q)
    );

    gpiop_fn_sel #(.NP(NPINS), .NCSP(NCSP)) u_fn (
        .ext       (ext),
        .busarb_en (busarb_en_i),
        .reqo_en   (reqo_en_i),
        .cs_en     (cs_en_i),
        .ddr       (ddr_q),
        .fn_o      (fn)
    );

    always_comb begin
        alt_val              = '0;
        alt_val[NCSP-1:0]    = cs_n_i[NCSP-1:0];
        alt_val[PIN_RQO]     = reqo_en_i ? breqo_n_i : cs_n_i[NCSP];
        alt_val[PIN_ACK]     = back_n_i;
    end

    gpiop_pin_drv #(.NP(NPINS)) u_drv (
        .fn       (fn),
        .ddr      (ddr_q),
        .dr       (dr_q),
        .alt_val  (alt_val),
        .pin_i    (pin_i),
        .pin_o    (pin_o),
        .pin_oe_o (pin_oe_o),
        .rd_bits  (rd_bits)
    );

    assign breq_n_o  = (fn[PIN_REQ] == FN_ALT_IN) ? pin_i[PIN_REQ] : 1'b1;
    assign rd_data_o = rd_sel_i ? 8'hFF : {1'b1, rd_bits};

    // R9: without expansion every pin follows the registers
    a_r9_single_chip_plain: assert property (@(posedge clk) disable iff (!rst_n)
        !ext |-> (pin_oe_o == ddr_q && ((pin_o ^ dr_q) & ddr_q) == '0));

    // R6: acknowledge driven and request pin released while arbitration is active
    a_r6_ack_driven: assert property (@(posedge clk) disable iff (!rst_n)
        (ext && busarb_en_i) |->
            (pin_oe_o[PIN_ACK] && pin_o[PIN_ACK] == back_n_i && !pin_oe_o[PIN_REQ]));

    // R7: request-out overrides chip select 7
    a_r7_reqo_priority: assert property (@(posedge clk) disable iff (!rst_n)
        (ext && reqo_en_i) |-> (pin_oe_o[PIN_RQO] && pin_o[PIN_RQO] == breqo_n_i));

    // R8: enabled chip-select pin with clear direction bit is released
    a_r8_cs_input_released: assert property (@(posedge clk) disable iff (!rst_n)
        (ext && cs_en_i[0] && !ddr_q[0]) |-> !pin_oe_o[0]);

    // R2: direction reads as all ones
    a_r2_dir_reads_ones: assert property (@(posedge clk) disable iff (!rst_n)
        rd_sel_i |-> (rd_data_o == 8'hFF));

endmodule

// File: tb/tb_gpio_altfn_port.sv
module tb_gpio_altfn_port;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] mode_i = 3'd7;
    logic       expe_i = 1'b0;
    logic       wr_en_i = 1'b0, wr_sel_i = 1'b0, rd_sel_i = 1'b0;
    logic [7:0] wr_data_i = '0;
    logic [7:0] rd_data_o;
    logic       busarb_en_i = 1'b0, reqo_en_i = 1'b0;
    logic [4:0] cs_en_i = '0;
    logic [4:0] cs_n_i = 5'b10101;
    logic       back_n_i = 1'b0, breqo_n_i = 1'b0;
    logic       breq_n_o;
    logic [6:0] pin_i = 7'b0011001;
    logic [6:0] pin_o, pin_oe_o;

    int n_chk = 0, n_bad = 0;

    always #2 clk = ~clk;

    gpio_altfn_port dut (.*);

    // vector: mode,expe,arb,reqo,cs_en,ddr,dr | exp_oe,exp_out,exp_rd,exp_breq
    typedef struct packed {
        logic [2:0] mode;
        logic       expe;
        logic       arb;
        logic       reqo;
        logic [4:0] csen;
        logic [6:0] ddr;
        logic [6:0] dr;
        logic [6:0] oe;
        logic [6:0] outv;
        logic [7:0] rd;
        logic       breq;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VT [NV] = '{
        '{3'd7,1'b0,1'b1,1'b1,5'b11111,7'b1111111,7'b1010101,7'b1111111,7'b1010101,8'hD5,1'b1},
        '{3'd7,1'b0,1'b1,1'b1,5'b11111,7'b0001111,7'b1111111,7'b0001111,7'b0001111,8'h9F,1'b1},
        '{3'd7,1'b1,1'b1,1'b0,5'b00000,7'b0000000,7'b0000000,7'b0100000,7'b0000000,8'h99,1'b0},
        '{3'd1,1'b0,1'b0,1'b1,5'b10000,7'b0000000,7'b0000000,7'b0010000,7'b0000000,8'h99,1'b1},
        '{3'd2,1'b0,1'b0,1'b0,5'b11111,7'b1111111,7'b0000000,7'b1111111,7'b0010101,8'h99,1'b1},
        '{3'd4,1'b0,1'b0,1'b0,5'b11111,7'b0000101,7'b1111111,7'b0000101,7'b0000101,8'h99,1'b1},
        '{3'd4,1'b0,1'b1,1'b1,5'b10000,7'b0010000,7'b1111111,7'b0110000,7'b0000000,8'h99,1'b0},
        '{3'd3,1'b0,1'b1,1'b1,5'b11111,7'b1100000,7'b0100000,7'b1100000,7'b0100000,8'hB9,1'b1},
        '{3'd7,1'b1,1'b0,1'b0,5'b00001,7'b0000001,7'b0000000,7'b0000001,7'b0000001,8'h99,1'b1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic do_reset(input logic [2:0] m, input logic e);
        @(negedge clk);
        mode_i = m; expe_i = e; busarb_en_i = 0; reqo_en_i = 0; cs_en_i = '0;
        rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #300000;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R1 / R10: reset in mode 1 drives pin 0 as output low
        do_reset(3'd1, 1'b0);
        check("R1 oe mode1", 32'(pin_oe_o), 32'h01);
        check("R1 out mode1", 32'(pin_o & pin_oe_o), 32'h00);
        rd_sel_i = 1'b0; #0;
        check("R3 rd after reset mode1", 32'(rd_data_o), {24'h0, 1'b1, pin_i[6:1], 1'b0});
        do_reset(3'd2, 1'b0);
        check("R1 oe mode2", 32'(pin_oe_o), 32'h01);
        do_reset(3'd4, 1'b0);
        check("R1 oe mode4", 32'(pin_oe_o), 32'h00);
        do_reset(3'd7, 1'b0);
        check("R1 oe mode7", 32'(pin_oe_o), 32'h00);

        // R2: direction reads all ones, bit 7 ignored on write
        rd_sel_i = 1'b1;
        wr(1'b1, 8'h80);
        check("R2 dir read", 32'(rd_data_o), 32'hFF);
        check("R2 bit7 ignored oe", 32'(pin_oe_o), 32'h00);
        rd_sel_i = 1'b0;

        // R4: data write takes effect at next edge, not before
        wr(1'b1, 8'h7F);
        @(negedge clk);
        wr_en_i = 1'b1; wr_sel_i = 1'b0; wr_data_i = 8'h2A;
        #1;
        check("R4 before edge", 32'(pin_o), 32'h00);
        @(posedge clk); #1;
        wr_en_i = 1'b0;
        check("R4 after edge", 32'(pin_o), 32'h2A);

        // table walk: R3 R5 R6 R7 R8 R9 R10
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            mode_i = VT[v].mode; expe_i = VT[v].expe;
            busarb_en_i = VT[v].arb; reqo_en_i = VT[v].reqo; cs_en_i = VT[v].csen;
            wr(1'b1, {1'b0, VT[v].ddr});
            wr(1'b0, {1'b0, VT[v].dr});
            rd_sel_i = 1'b0;
            #1;
            check($sformatf("R5 R6 R7 R8 R9 R10 oe v%0d", v), 32'(pin_oe_o), 32'(VT[v].oe));
            check($sformatf("R5 R6 R7 R8 out v%0d", v), 32'(pin_o & pin_oe_o), 32'(VT[v].outv));
            check($sformatf("R3 rd v%0d", v), 32'(rd_data_o), 32'(VT[v].rd));
            check($sformatf("R6 breq v%0d", v), 32'(breq_n_o), 32'(VT[v].breq));
        end

        // R6: breq follows pin 6 level live
        @(negedge clk);
        mode_i = 3'd1; busarb_en_i = 1'b1; pin_i[6] = 1'b1;
        #1;
        check("R6 breq follows pin", 32'(breq_n_o), 32'h1);
        pin_i[6] = 1'b0; #1;
        check("R6 breq follows pin low", 32'(breq_n_o), 32'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule